// File: doc/BRIEF.md
# Clock Synthesizer Configuration Bridge

This block is a memory-mapped register slave that gives software access to the 16-bit dynamic reconfiguration port of a clock synthesizer. Software reaches it through a simple 32-bit register bus with single-cycle write strobes and read strobes. A single write to the control register launches a complete port transaction, either a read or a write. Software then polls the busy flag in the status register. When busy drops after a read, the low half of that same status word holds the data the synthesizer returned.

A separate reset register drives two outputs. One releases the surrounding clock logic from reset. The other takes the synthesizer itself out of reset. The synthesizer answers each port transaction by raising ready for one cycle, after a latency it chooses. Software must not start a new transaction while busy is set. The block also protects itself: a start request that arrives while busy is set is dropped.

Top module: `clkbr_bridge`

## Requirements
- R1: After reset, cfg_en is 0, core_release is 0, synth_reset is 1, and a read of the status register (offset 0x74) returns 0.
- R2: A bus write to offset 0x70 with bit 29 set, made while idle, raises cfg_en for the next cycle. In that cycle cfg_we equals the inverse of bit 28 (bit 28 set means a read), cfg_addr equals bits 22:16 and cfg_wdata equals bits 15:0.
- R3: Status bit 16 (busy) reads 1 from the cycle after a launching write until the cycle in which cfg_rdy is sampled high. It reads 0 from the cycle after that.
- R4: When cfg_rdy is high during an outstanding read, cfg_rdata is captured, and status bits 15:0 return it from the next cycle.
- R5: Completion of a write transaction leaves status bits 15:0 unchanged.
- R6: A control write arriving while busy is set starts nothing. It leaves cfg_addr, cfg_wdata, cfg_we and the stored control word unchanged.
- R7: A write to offset 0x70 with bit 29 clear starts no transaction, and busy stays 0.
- R8: cfg_en is high for exactly one cycle per transaction. cfg_addr, cfg_wdata and cfg_we hold steady from the cfg_en cycle until cfg_rdy.
- R9: A write to offset 0x40 sets core_release to bit 0 and synth_reset to the inverse of bit 1 from the next cycle. A read of 0x40 returns those two bits in bits 1:0.
- R10: bus_rdata is valid in the cycle after bus_rd. Offset 0x70 reads back the last accepted control word. Other offsets read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after bus_rd |
| cfg_en | output | 1 | Port transaction strobe, one cycle |
| cfg_we | output | 1 | Port write enable (1 means write) |
| cfg_addr | output | 7 | Port register address |
| cfg_wdata | output | 16 | Port write data |
| cfg_rdata | input | 16 | Port read data, valid with cfg_rdy |
| cfg_rdy | input | 1 | Port transaction complete |
| core_release | output | 1 | Releases the surrounding logic from reset |
| synth_reset | output | 1 | Holds the synthesizer in reset while 1 |

## Verification
The bench drives every input half a cycle before a rising edge and samples half a cycle after it. A launching write therefore shows cfg_en and the port fields at the very next sample point. Status reads return the busy flag as it stood at the edge where the read was taken. This makes busy visible from the sample right after cfg_en, and clear at the sample right after the cycle in which ready was driven. Captured read data and the reset-register outputs are due one edge after their cause, and each check samples at exactly that point. The responder latency runs from zero to several cycles, so ready can arrive in the same cycle as the strobe or well after it.

// File: rtl/clkbr_pkg.sv
// Package: register offsets and bit positions shared by the bridge modules.
// Assumes byte offsets on an 8-bit bus address.
package clkbr_pkg;
    localparam logic [7:0] OFS_RESET  = 8'h40;
    localparam logic [7:0] OFS_CTRL   = 8'h70;
    localparam logic [7:0] OFS_STATUS = 8'h74;
    localparam int START_BIT = 29;
    localparam int READ_BIT  = 28;
    localparam int ADDR_LSB  = 16;
    localparam int BUSY_BIT  = 16;
endpackage

// File: rtl/clkbr_xact.sv
// Module: clkbr_xact
// Runs one reconfiguration-port transaction per accepted control word.
// It stores the word, pulses the strobe, holds the fields and tracks busy,
// and captures read data on ready.
// Assumes ready only matters while busy is set.
module clkbr_xact
    import clkbr_pkg::*;
#(
    parameter int BUS_DW = 32,
    parameter int PAW    = 7,
    parameter int PDW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [BUS_DW-1:0] launch_word,
    input  logic              cfg_rdy,
    input  logic [PDW-1:0]    cfg_rdata,
    output logic              cfg_en,
    output logic              cfg_we,
    output logic [PAW-1:0]    cfg_addr,
    output logic [PDW-1:0]    cfg_wdata,
    output logic              busy,
    output logic [PDW-1:0]    rd_capt,
    output logic [BUS_DW-1:0] ctrl_word
);
    logic              busy_q;
    logic              en_q;
    logic [BUS_DW-1:0] word_q;
    logic [PDW-1:0]    capt_q;

    // Accept a start when idle, retire on ready, capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            en_q   <= 1'b0;
            word_q <= '0;
            capt_q <= '0;
        end else begin
            en_q <= 1'b0;
            if (!busy_q && launch) begin
                busy_q <= 1'b1;
                en_q   <= 1'b1;
                word_q <= launch_word;
            end else if (busy_q && cfg_rdy) begin
                busy_q <= 1'b0;
                if (word_q[READ_BIT]) begin
                    capt_q <= cfg_rdata;
                end
            end
        end
    end

    // Drive port fields straight from the stored control word.
    always_comb begin
        cfg_en    = en_q;
        cfg_we    = ~word_q[READ_BIT];
        cfg_addr  = word_q[ADDR_LSB +: PAW];
        cfg_wdata = word_q[PDW-1:0];
        busy      = busy_q;
        rd_capt   = capt_q;
        ctrl_word = word_q;
    end
endmodule

// File: rtl/clkbr_regs.sv
// Module: clkbr_regs
// Decodes the register bus. It holds the reset register, flags start
// requests, and registers the readback mux.
// Assumes full-offset decode; unmapped offsets read 0.
module clkbr_regs
    import clkbr_pkg::*;
#(
    parameter int BUS_AW = 8,
    parameter int BUS_DW = 32,
    parameter int PDW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              busy,
    input  logic [PDW-1:0]    rd_capt,
    input  logic [BUS_DW-1:0] ctrl_word,
    output logic              launch,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              core_release,
    output logic              synth_reset
);
    localparam int RST_W = 2;

    logic [RST_W-1:0]  rst_q;
    logic [BUS_DW-1:0] rdata_q;
    logic [BUS_DW-1:0] rdata_d;

    // Flag a start request: a control write carrying the start bit.
    always_comb begin
        launch = bus_wr && (bus_addr == BUS_AW'(OFS_CTRL)) && bus_wdata[START_BIT];
    end

    // Reset register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_q <= '0;
        end else if (bus_wr && (bus_addr == BUS_AW'(OFS_RESET))) begin
            rst_q <= bus_wdata[RST_W-1:0];
        end
    end

    // Readback selection by offset.
    always_comb begin
        rdata_d = '0;
        if (bus_addr == BUS_AW'(OFS_RESET)) begin
            rdata_d[RST_W-1:0] = rst_q;
        end else if (bus_addr == BUS_AW'(OFS_STATUS)) begin
            rdata_d[PDW-1:0]  = rd_capt;
            rdata_d[BUSY_BIT] = busy;
        end else if (bus_addr == BUS_AW'(OFS_CTRL)) begin
            rdata_d = ctrl_word;
        end
    end

    // Register read data one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rdata_d;
        end
    end

    // Drive outputs from the reset register and read buffer.
    always_comb begin
        bus_rdata    = rdata_q;
        core_release = rst_q[0];
        synth_reset  = ~rst_q[1];
    end
endmodule

// File: rtl/clkbr_bridge.sv
// Module: clkbr_bridge (top)
// Register bus to synthesizer reconfiguration-port bridge.
// Assumes software waits for busy to clear before starting again.
module clkbr_bridge #(
    parameter int BUS_AW = 8,
    parameter int BUS_DW = 32,
    parameter int PAW    = 7,
    parameter int PDW    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              cfg_en,
    output logic              cfg_we,
    output logic [PAW-1:0]    cfg_addr,
    output logic [PDW-1:0]    cfg_wdata,
    input  logic [PDW-1:0]    cfg_rdata,
    input  logic              cfg_rdy,
    output logic              core_release,
    output logic              synth_reset
);
    logic              launch;
    logic              busy;
    logic [PDW-1:0]    rd_capt;
    logic [BUS_DW-1:0] ctrl_word;

    clkbr_regs #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .PDW(PDW)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
        .rd_capt(rd_capt), .ctrl_word(ctrl_word), .launch(launch),
        .bus_rdata(bus_rdata), .core_release(core_release),
        .synth_reset(synth_reset)
    );

    clkbr_xact #(.BUS_DW(BUS_DW), .PAW(PAW), .PDW(PDW)) u_xact (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_word(bus_wdata),
        .cfg_rdy(cfg_rdy), .cfg_rdata(cfg_rdata), .cfg_en(cfg_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .busy(busy), .rd_capt(rd_capt), .ctrl_word(ctrl_word)
    );
endmodule

// File: rtl/clkbr_bridge_chk.sv
// Module: clkbr_bridge_chk
// Port-level protocol checks for clkbr_bridge, attached by bind.
// It tracks the outstanding transaction from cfg_en and cfg_rdy.
module clkbr_bridge_chk #(
    parameter int BUS_AW = 8,
    parameter int BUS_DW = 32,
    parameter int PAW    = 7,
    parameter int PDW    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BUS_DW-1:0] bus_wdata,
    input logic              cfg_en,
    input logic              cfg_we,
    input logic [PAW-1:0]    cfg_addr,
    input logic [PDW-1:0]    cfg_wdata,
    input logic              cfg_rdy,
    input logic              core_release,
    input logic              synth_reset
);
    logic out_q;

    // Track a transaction from its strobe until its ready.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else if (cfg_en) out_q <= ~cfg_rdy;
        else if (cfg_rdy) out_q <= 1'b0;
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> !cfg_en);
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q && !cfg_rdy) |=> ($stable(cfg_addr) && $stable(cfg_wdata) && $stable(cfg_we)));
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> !out_q);
    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BUS_AW'(8'h70) && bus_wdata[29] && !out_q && !cfg_en) |=> cfg_en);
    a_r9_reset_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BUS_AW'(8'h40)) |=>
        (core_release == $past(bus_wdata[0]) && synth_reset == !$past(bus_wdata[1])));
endmodule

bind clkbr_bridge clkbr_bridge_chk #(.BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .PAW(PAW), .PDW(PDW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdy(cfg_rdy),
    .core_release(core_release), .synth_reset(synth_reset)
);

// File: tb/clkbr_bridge_test.sv
`timescale 1ns/1ps
module clkbr_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_en, cfg_we;
    logic [6:0]  cfg_addr;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata = '0;
    logic        cfg_rdy = 1'b0;
    logic        core_release, synth_reset;

    int checks = 0;
    int fails  = 0;
    logic [15:0] exp_data = '0;

    always #4 clk = ~clk;

    clkbr_bridge uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_rdy(cfg_rdy),
        .core_release(core_release), .synth_reset(synth_reset)
    );

    typedef struct packed {
        logic        rd;
        logic [6:0]  addr;
        logic [15:0] wdata;
        logic [15:0] resp;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 7'h08, 16'h1234, 16'h0000, 4'd2},
        '{1'b1, 7'h08, 16'h0000, 16'hBEEF, 4'd3},
        '{1'b0, 7'h16, 16'h0041, 16'h5555, 4'd0},
        '{1'b1, 7'h4E, 16'h0000, 16'h9900, 4'd1},
        '{1'b1, 7'h7F, 16'h0000, 16'h0001, 4'd5},
        '{1'b0, 7'h4F, 16'hFFFF, 16'hAAAA, 4'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        step();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic respond(input logic [15:0] data);
        cfg_rdy = 1'b1; cfg_rdata = data;
        step();
        cfg_rdy = 1'b0; cfg_rdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL timeout R1 actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] word;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 cfg_en", {31'b0, cfg_en}, 32'd0);
        chk("R1 core_release", {31'b0, core_release}, 32'd0);
        chk("R1 synth_reset", {31'b0, synth_reset}, 32'd1);
        bus_read(8'h74, rv);
        chk("R1 status", rv, 32'h0);

        // Table-driven transactions
        foreach (VECS[i]) begin
            word = (32'd1 << 29) | ({31'b0, VECS[i].rd} << 28) |
                   ({25'b0, VECS[i].addr} << 16) | {16'b0, VECS[i].wdata};
            bus_write(8'h70, word);
            chk("R2 cfg_en", {31'b0, cfg_en}, 32'd1);
            chk("R2 cfg_we", {31'b0, cfg_we}, {31'b0, ~VECS[i].rd});
            chk("R2 cfg_addr", {25'b0, cfg_addr}, {25'b0, VECS[i].addr});
            chk("R2 cfg_wdata", {16'b0, cfg_wdata}, {16'b0, VECS[i].wdata});
            for (int k = 0; k < int'(VECS[i].lat); k++) begin
                bus_read(8'h74, rv);
                chk("R3 busy set", {31'b0, rv[16]}, 32'd1);
                chk("R8 single pulse", {31'b0, cfg_en}, 32'd0);
                chk("R8 stable", {cfg_we, 8'b0, cfg_addr, cfg_wdata},
                    {~VECS[i].rd, 8'b0, VECS[i].addr, VECS[i].wdata});
            end
            respond(VECS[i].resp);
            if (VECS[i].rd) exp_data = VECS[i].resp;
            bus_read(8'h74, rv);
            chk("R3 busy clear", {31'b0, rv[16]}, 32'd0);
            chk(VECS[i].rd ? "R4 read capture" : "R5 write keeps data",
                {16'b0, rv[15:0]}, {16'b0, exp_data});
            bus_read(8'h70, rv);
            chk("R10 ctrl readback", rv, word);
        end

        // R6 control write during busy is dropped
        word = (32'd1 << 29) | (32'd1 << 28) | (32'h11 << 16);
        bus_write(8'h70, word);
        step();
        bus_write(8'h70, (32'd1 << 29) | (32'h22 << 16) | 32'h7777);
        chk("R6 no strobe", {31'b0, cfg_en}, 32'd0);
        chk("R6 fields held", {cfg_we, 8'b0, cfg_addr, cfg_wdata}, {1'b0, 8'b0, 7'h11, 16'h0000});
        bus_read(8'h70, rv);
        chk("R6 ctrl word held", rv, word);
        respond(16'hC0DE);
        chk("R6 no late strobe", {31'b0, cfg_en}, 32'd0);
        bus_read(8'h74, rv);
        chk("R6 original read data", rv, 32'h0000C0DE);

        // R7 start bit clear
        bus_write(8'h70, (32'd1 << 28) | (32'h05 << 16));
        chk("R7 no strobe", {31'b0, cfg_en}, 32'd0);
        bus_read(8'h74, rv);
        chk("R7 busy clear", rv, 32'h0000C0DE);

        // R9 reset register
        bus_write(8'h40, 32'h1);
        chk("R9 release", {30'b0, core_release, synth_reset}, 32'h3);
        bus_write(8'h40, 32'h3);
        chk("R9 synth enabled", {30'b0, core_release, synth_reset}, 32'h2);
        bus_read(8'h40, rv);
        chk("R9 readback", rv, 32'h3);

        // R10 unmapped offsets
        bus_write(8'h44, 32'hFFFF_FFFF);
        bus_read(8'h44, rv);
        chk("R10 unmapped read", rv, 32'h0);
        bus_read(8'h40, rv);
        chk("R10 unmapped write ignored", rv, 32'h3);
        chk("R10 no strobe", {31'b0, cfg_en}, 32'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule